// File: doc/BRIEF.md
# Sidetone FIR Unit

This block turns a stream of signed 16-bit capture samples into two sidetone samples, one for each output channel. Each accepted sample goes into a history line. A single multiply-accumulate engine then walks all filter taps, one tap per clock. The accumulated sum is reduced to a Q15 value and scaled by a separate signed gain for each channel. Both results are saturated to 16 bits and presented together with a one-cycle valid pulse.

Software sets the unit up over a simple 32-bit register bus. One control word holds the enable and the coefficient-load handshake. Coefficients are streamed through a single data register rather than written to addresses; a load pointer advances on each write, and a read-only done bit reports that every tap has been filled. Both channel gains share one word. Other registers hold a sticky overrun event, an event mask bit, an auto-idle bit that lets the datapath stop clocking while sidetone is off, and a fixed revision value.

Top module: `sidetone_fir`

## Requirements
- R1: After reset, st_vld is 0, both outputs are 0, and the following registers read 0: control (0x2C), gain (0x24), event (0x18) and event mask (0x1C). The configuration register (0x10) reads 1.
- R2: A read of offset 0x00 returns the constant REV_ID. Writes to 0x00 leave that value unchanged.
- R3: Coefficients are loaded while control bit 1 is set. Successive writes to 0x28 then fill taps 0 to NTAPS-1 in order, each taking bits 15:0 of the write. Writes past the last tap, and writes made while bit 1 is clear, change no coefficient.
- R4: Control bit 2 (read-only) reads 1 once all NTAPS coefficients are written while bit 1 is set, and 0 before that. It returns to 0 when bit 1 is cleared. Clearing bit 1 and setting it again restarts the load at tap 0.
- R5: The gain register holds the channel 0 gain in bits 15:0 and the channel 1 gain in bits 31:16, both signed. It reads back as written.
- R6: For each accepted sample, the unit forms acc = sum over k of x[n-k]*h[k], where x[n] is the newest accepted sample and history from before the last enable counts as zero. The filter value is q = sat16(acc >>> 15), an arithmetic shift.
- R7: The channel 0 output is sat16((q*gain0) >>> 15), and the channel 1 output is the same using gain1. Saturation limits are -32768 and 32767.
- R8: st_vld is a single-cycle pulse. It rises NTAPS+1 clock edges after the edge that samples smp_stb, and both outputs change with it.
- R9: While control bit 0 is 0, both outputs are 0 and st_vld stays 0. Strobes are ignored, and the sample history is cleared.
- R10: A strobe that arrives while enabled and busy is dropped and sets bit 0 of the event register (0x18). That bit is sticky. Writing 1 to it clears it; writing 0 has no effect.
- R11: Bit 0 of the event mask (0x1C) and bit 0 of the configuration register (0x10, auto-idle) read back as written. Any unmapped offset reads 0.
- R12: Control bits 0 (enable) and 1 (coefficient write enable) read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| smp_stb | input | 1 | One-cycle strobe: a capture sample is present |
| smp_data | input | 16 | Signed capture sample |
| st_vld | output | 1 | Pulse: both sidetone outputs are updated |
| st_out0 | output | 16 | Signed sidetone sample, channel 0 |
| st_out1 | output | 16 | Signed sidetone sample, channel 1 |

## Verification
The assertions take for granted that a register access lasts one cycle, that smp_stb is a single-cycle pulse, and that coefficients are not reloaded while a sample is being filtered. The bench keeps to these conditions. It lets each sample finish before it sends the next, except in one deliberate overrun case. It does all loads while the engine is idle, and it drives the bus only through single-cycle tasks. The bench builds the unit with 16 taps. It sweeps every pair from a set of extreme and mid-range gains, and it forces both saturation directions.

// File: rtl/sidetone_pkg.sv
package sidetone_pkg;
  localparam int SMP_W  = 16;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;

  localparam logic [ADDR_W-1:0] A_ID    = 8'h00;
  localparam logic [ADDR_W-1:0] A_CFG   = 8'h10;
  localparam logic [ADDR_W-1:0] A_EVT   = 8'h18;
  localparam logic [ADDR_W-1:0] A_EVTEN = 8'h1C;
  localparam logic [ADDR_W-1:0] A_GAIN  = 8'h24;
  localparam logic [ADDR_W-1:0] A_TAP   = 8'h28;
  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h2C;

  localparam logic signed [63:0] SMP_MAX = (64'sd1 <<< (SMP_W-1)) - 64'sd1;
  localparam logic signed [63:0] SMP_MIN = -SMP_MAX - 64'sd1;

  typedef enum logic [1:0] {M_IDLE, M_RUN, M_SCALE} mac_state_e;

  function automatic logic signed [SMP_W-1:0] sat_smp(input logic signed [63:0] v);
    logic signed [63:0] c;
    if (v > SMP_MAX)      c = SMP_MAX;
    else if (v < SMP_MIN) c = SMP_MIN;
    else                  c = v;
    return c[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/st_coef_store.sv
module st_coef_store
  import sidetone_pkg::*;
#(
  parameter int NTAPS = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(NTAPS)-1:0] waddr,
  input  logic [SMP_W-1:0]         wdata,
  input  logic [$clog2(NTAPS)-1:0] raddr,
  output logic [SMP_W-1:0]         rdata
);
  logic [SMP_W-1:0] mem_q [NTAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/st_history.sv
module st_history
  import sidetone_pkg::*;
#(
  parameter int NTAPS = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     shift,
  input  logic [SMP_W-1:0]         din,
  input  logic [$clog2(NTAPS)-1:0] ridx,
  output logic [SMP_W-1:0]         dout
);
  localparam int LINE_W = NTAPS * SMP_W;

  logic [LINE_W-1:0] line_q, line_d;
  logic              line_ce;

  always_comb begin
    line_ce = clr | shift;
    if (clr) line_d = '0;
    else     line_d = {line_q[LINE_W-SMP_W-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (line_ce) line_q <= line_d;
  end

  assign dout = line_q[ridx*SMP_W +: SMP_W];
endmodule

// File: rtl/st_mac.sv
module st_mac
  import sidetone_pkg::*;
#(
  parameter int NTAPS = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     auto_idle,
  input  logic                     start,
  input  logic [SMP_W-1:0]         hdata,
  input  logic [SMP_W-1:0]         cdata,
  input  logic [SMP_W-1:0]         gain0,
  input  logic [SMP_W-1:0]         gain1,
  output logic [$clog2(NTAPS)-1:0] idx,
  output logic                     busy,
  output logic                     vld,
  output logic [SMP_W-1:0]         out0,
  output logic [SMP_W-1:0]         out1
);
  localparam int IW    = $clog2(NTAPS);
  localparam int PRD_W = 2 * SMP_W;
  localparam int ACC_W = PRD_W + IW;
  localparam logic [IW-1:0] LAST = IW'(NTAPS - 1);

  mac_state_e               state_q, state_d;
  logic [IW-1:0]            idx_q, idx_d;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic [SMP_W-1:0]         o0_q, o0_d, o1_q, o1_d;
  logic                     vld_q, vld_d;
  logic                     dp_ce;
  logic signed [PRD_W-1:0]  prod;
  logic signed [SMP_W-1:0]  q15;
  logic signed [63:0]       acc_sh, p0, p1;

  always_comb begin
    dp_ce  = en | ~auto_idle;
    prod   = $signed(hdata) * $signed(cdata);
    acc_sh = acc_q >>> (SMP_W - 1);
    q15    = sat_smp(acc_sh);
    p0     = 64'(q15) * 64'($signed(gain0));
    p1     = 64'(q15) * 64'($signed(gain1));

    state_d = state_q;
    idx_d   = idx_q;
    acc_d   = acc_q;
    o0_d    = o0_q;
    o1_d    = o1_q;
    vld_d   = 1'b0;
    case (state_q)
      M_IDLE: begin
        if (start) begin
          state_d = M_RUN;
          idx_d   = '0;
          acc_d   = '0;
        end
      end
      M_RUN: begin
        acc_d = acc_q + {{(ACC_W-PRD_W){prod[PRD_W-1]}}, prod};
        idx_d = idx_q + IW'(1);
        if (idx_q == LAST) state_d = M_SCALE;
      end
      M_SCALE: begin
        o0_d    = sat_smp(p0 >>> (SMP_W - 1));
        o1_d    = sat_smp(p1 >>> (SMP_W - 1));
        vld_d   = 1'b1;
        state_d = M_IDLE;
      end
      default: state_d = M_IDLE;
    endcase
    if (!en) begin
      state_d = M_IDLE;
      o0_d    = '0;
      o1_d    = '0;
      vld_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      o0_q    <= '0;
      o1_q    <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      o0_q    <= o0_d;
      o1_q    <= o1_d;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (dp_ce) begin
      idx_q <= idx_d;
      acc_q <= acc_d;
    end
  end

  assign idx  = idx_q;
  assign busy = (state_q != M_IDLE);
  assign vld  = vld_q;
  assign out0 = o0_q;
  assign out1 = o1_q;
endmodule

// File: rtl/st_regs.sv
module st_regs
  import sidetone_pkg::*;
#(
  parameter int          NTAPS  = 128,
  parameter logic [31:0] REV_ID = 32'h0001_0300
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [BUS_W-1:0]         bus_wdata,
  output logic [BUS_W-1:0]         bus_rdata,
  input  logic                     ovr_evt,
  output logic                     sidetone_on,
  output logic                     auto_idle,
  output logic                     coef_we,
  output logic                     coef_done,
  output logic                     ovr_flag,
  output logic [$clog2(NTAPS)-1:0] coef_waddr,
  output logic [SMP_W-1:0]         coef_wdata,
  output logic [SMP_W-1:0]         gain0,
  output logic [SMP_W-1:0]         gain1
);
  localparam int IW = $clog2(NTAPS);
  localparam int PW = $clog2(NTAPS + 1);
  localparam logic [PW-1:0] FULL = PW'(NTAPS);

  logic             en_q, en_d, wren_q, wren_d, idle_q, idle_d;
  logic             ovr_q, ovr_d, ovren_q, ovren_d;
  logic [SMP_W-1:0] g0_q, g0_d, g1_q, g1_d;
  logic [PW-1:0]    ptr_q, ptr_d;
  logic             wr, tap_wr, evt_clr;

  always_comb begin
    wr      = bus_sel & bus_we;
    tap_wr  = wr & (bus_addr == A_TAP);
    evt_clr = wr & (bus_addr == A_EVT) & bus_wdata[0];
    en_d    = en_q;
    wren_d  = wren_q;
    idle_d  = idle_q;
    ovren_d = ovren_q;
    g0_d    = g0_q;
    g1_d    = g1_q;
    if (wr) begin
      case (bus_addr)
        A_CTRL:  begin en_d = bus_wdata[0]; wren_d = bus_wdata[1]; end
        A_CFG:   idle_d  = bus_wdata[0];
        A_EVTEN: ovren_d = bus_wdata[0];
        A_GAIN:  begin g0_d = bus_wdata[15:0]; g1_d = bus_wdata[31:16]; end
        default: ;
      endcase
    end
    coef_we = tap_wr & wren_q & (ptr_q != FULL);
    if (!wren_q)      ptr_d = '0;
    else if (coef_we) ptr_d = ptr_q + PW'(1);
    else              ptr_d = ptr_q;
    ovr_d = (ovr_q & ~evt_clr) | ovr_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      wren_q  <= 1'b0;
      idle_q  <= 1'b1;
      ovr_q   <= 1'b0;
      ovren_q <= 1'b0;
      g0_q    <= '0;
      g1_q    <= '0;
      ptr_q   <= '0;
    end else begin
      en_q    <= en_d;
      wren_q  <= wren_d;
      idle_q  <= idle_d;
      ovr_q   <= ovr_d;
      ovren_q <= ovren_d;
      g0_q    <= g0_d;
      g1_q    <= g1_d;
      ptr_q   <= ptr_d;
    end
  end

  assign coef_done   = wren_q & (ptr_q == FULL);
  assign coef_waddr  = ptr_q[IW-1:0];
  assign coef_wdata  = bus_wdata[SMP_W-1:0];
  assign sidetone_on = en_q;
  assign auto_idle   = idle_q;
  assign ovr_flag    = ovr_q;
  assign gain0       = g0_q;
  assign gain1       = g1_q;

  always_comb begin
    case (bus_addr)
      A_ID:    bus_rdata = REV_ID;
      A_CFG:   bus_rdata = {31'd0, idle_q};
      A_EVT:   bus_rdata = {31'd0, ovr_q};
      A_EVTEN: bus_rdata = {31'd0, ovren_q};
      A_GAIN:  bus_rdata = {g1_q, g0_q};
      A_CTRL:  bus_rdata = {29'd0, coef_done, wren_q, en_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sidetone_fir.sv
module sidetone_fir
  import sidetone_pkg::*;
#(
  parameter int          NTAPS  = 128,
  parameter logic [31:0] REV_ID = 32'h0001_0300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        smp_stb,
  input  logic [15:0] smp_data,
  output logic        st_vld,
  output logic [15:0] st_out0,
  output logic [15:0] st_out1
);
  localparam int IW = $clog2(NTAPS);

  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic             sidetone_on, auto_idle, coef_we, coef_done, ovr_flag;
  logic             mac_busy, accept, ovr_evt;
  logic [IW-1:0]    coef_waddr, mac_idx;
  logic [SMP_W-1:0] coef_wdata, coef_rdata, hist_rdata, gain0, gain1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign accept  = smp_stb & sidetone_on & ~mac_busy;
  assign ovr_evt = smp_stb & sidetone_on & mac_busy;

  st_regs #(.NTAPS(NTAPS), .REV_ID(REV_ID)) u_regs (
    .clk(clk), .rst_n(rst_i_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovr_evt(ovr_evt),
    .sidetone_on(sidetone_on), .auto_idle(auto_idle),
    .coef_we(coef_we), .coef_done(coef_done), .ovr_flag(ovr_flag),
    .coef_waddr(coef_waddr), .coef_wdata(coef_wdata),
    .gain0(gain0), .gain1(gain1)
  );

  st_coef_store #(.NTAPS(NTAPS)) u_coef (
    .clk(clk), .rst_n(rst_i_n),
    .we(coef_we), .waddr(coef_waddr), .wdata(coef_wdata),
    .raddr(mac_idx), .rdata(coef_rdata)
  );

  st_history #(.NTAPS(NTAPS)) u_hist (
    .clk(clk), .rst_n(rst_i_n),
    .clr(~sidetone_on), .shift(accept), .din(smp_data),
    .ridx(mac_idx), .dout(hist_rdata)
  );

  st_mac #(.NTAPS(NTAPS)) u_mac (
    .clk(clk), .rst_n(rst_i_n),
    .en(sidetone_on), .auto_idle(auto_idle), .start(accept),
    .hdata(hist_rdata), .cdata(coef_rdata),
    .gain0(gain0), .gain1(gain1),
    .idx(mac_idx), .busy(mac_busy),
    .vld(st_vld), .out0(st_out0), .out1(st_out1)
  );
endmodule

// File: rtl/st_fir_chk.sv
module st_fir_chk
  import sidetone_pkg::*;
#(
  parameter int          NTAPS  = 128,
  parameter logic [31:0] REV_ID = 32'h0001_0300
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_rdata,
  input logic        smp_stb,
  input logic        st_vld,
  input logic [15:0] st_out0,
  input logic [15:0] st_out1,
  input logic        sidetone_on,
  input logic        mac_busy,
  input logic        coef_we,
  input logic        coef_done,
  input logic        ovr_flag
);
  always_comb begin
    if (bus_addr == A_ID)
      assert_rev_const_R2: assert (bus_rdata == REV_ID);
  end

  assert_vld_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_vld |=> !st_vld);

  assert_vld_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_vld |-> $past(mac_busy));

  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sidetone_on |=> (st_out0 == '0 && st_out1 == '0 && !st_vld));

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && sidetone_on && mac_busy) |=> ovr_flag);

  assert_done_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coef_done) |-> $past(coef_we));
endmodule

bind sidetone_fir st_fir_chk #(.NTAPS(NTAPS), .REV_ID(REV_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .smp_stb(smp_stb), .st_vld(st_vld), .st_out0(st_out0), .st_out1(st_out1),
  .sidetone_on(sidetone_on), .mac_busy(mac_busy), .coef_we(coef_we),
  .coef_done(coef_done), .ovr_flag(ovr_flag)
);

// File: tb/sidetone_fir_tb.sv
`timescale 1ns/1ps
module sidetone_fir_tb;
  localparam int NT = 16;
  localparam logic [31:0] REV = 32'h0001_0300;

  logic        clk, rst_n, bus_sel, bus_we, smp_stb;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] smp_data, st_out0, st_out1;
  logic        st_vld;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  int m_coef[NT];
  int m_hist[NT];
  int m_g0 = 0, m_g1 = 0;
  logic [31:0] lf = 32'h1234_5678;

  sidetone_fir #(.NTAPS(NT), .REV_ID(REV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smp_stb(smp_stb), .smp_data(smp_data),
    .st_vld(st_vld), .st_out0(st_out0), .st_out1(st_out1)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int rnd16();
    lf = lf * 32'd1664525 + 32'd1013904223;
    return int'($signed(lf[31:16]));
  endfunction

  function automatic void hist_clear();
    for (int k = 0; k < NT; k++) m_hist[k] = 0;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata; bus_sel = 0;
  endtask

  // R3/R4: stream m_coef through the data register, upper bits junk
  task automatic load_coefs(input bit en);
    logic [31:0] r;
    wr(8'h2C, {30'd0, 1'b1, en});
    for (int k = 0; k < NT; k++) begin
      if (k == NT - 1) begin
        rd(8'h2C, r); chk("R4 done low before last tap", r[2], 0);
      end
      wr(8'h28, {16'hA5A5, 16'(m_coef[k])});
    end
    rd(8'h2C, r); chk("R4 done after all taps", r[2], 1);
    wr(8'h28, 32'h0000_7777);          // R3 beyond last tap: ignored
    wr(8'h2C, {31'd0, en});
    rd(8'h2C, r); chk("R4 done clears with write enable", r[2], 0);
  endtask

  task automatic send(input int x);
    longint acc;
    int q, cnt;
    @(negedge clk); smp_stb = 1; smp_data = 16'(x);
    @(negedge clk); smp_stb = 0;
    for (int k = NT - 1; k > 0; k--) m_hist[k] = m_hist[k-1];
    m_hist[0] = x;
    acc = 0;
    for (int k = 0; k < NT; k++) acc += longint'(m_hist[k]) * m_coef[k];
    q = sat(acc >>> 15);
    cnt = 0;
    while (!st_vld && cnt < NT + 10) begin @(negedge clk); cnt++; end
    chk("R8 latency", cnt, NT + 1);
    chk("R6/R7 ch0", $signed(st_out0), sat((longint'(q) * m_g0) >>> 15));
    chk("R6/R7 ch1", $signed(st_out1), sat((longint'(q) * m_g1) >>> 15));
    @(negedge clk);
    chk("R8 single pulse", st_vld, 0);
  endtask

  task automatic set_gain(input int g0, input int g1);
    m_g0 = g0; m_g1 = g1;
    wr(8'h24, {16'(g1), 16'(g0)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int gl[7] = '{-32768, -16384, -1, 0, 1, 12345, 32767};
    bit seen;
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    smp_stb = 0; smp_data = 0;
    hist_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 vld", st_vld, 0);
    chk("R1 out0", st_out0, 0);
    chk("R1 out1", st_out1, 0);
    rd(8'h2C, r); chk("R1 ctrl", r, 0);
    rd(8'h24, r); chk("R1 gain", r, 0);
    rd(8'h18, r); chk("R1 event", r, 0);
    rd(8'h1C, r); chk("R1 mask", r, 0);
    rd(8'h10, r); chk("R1 cfg autoidle", r, 1);

    // R2 revision
    rd(8'h00, r); chk("R2 revision", r, REV);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, r); chk("R2 revision after write", r, REV);

    // R11 misc registers
    wr(8'h1C, 32'h1); rd(8'h1C, r); chk("R11 mask", r, 1);
    wr(8'h10, 32'h0); rd(8'h10, r); chk("R11 cfg", r, 0);
    wr(8'h10, 32'h1); rd(8'h10, r); chk("R11 cfg set", r, 1);
    rd(8'h04, r); chk("R11 unmapped", r, 0);

    // R12 control readback, R4 restart at tap 0
    wr(8'h2C, 32'h3); rd(8'h2C, r); chk("R12 ctrl bits", r, 3);
    for (int k = 0; k < 5; k++) wr(8'h28, 32'h0000_1111);
    wr(8'h2C, 32'h1); rd(8'h2C, r); chk("R12 ctrl enable only", r, 1);

    // set A: alternating, growing taps
    for (int k = 0; k < NT; k++) m_coef[k] = ((k % 2) ? -1 : 1) * (k + 1) * 1900;
    load_coefs(1'b1);

    // R5 gain readback
    set_gain(16384, -12000);
    rd(8'h24, r); chk("R5 gain packing", r, {16'(-12000), 16'(16384)});

    // R3 writes with write enable clear are ignored
    for (int k = 0; k < 3; k++) wr(8'h28, 32'h0000_4444);
    send(32767);
    for (int k = 0; k < NT + 2; k++) send(0);   // impulse response

    // R6/R7 gain sweep, all pairs
    foreach (gl[i]) foreach (gl[j]) begin
      set_gain(gl[i], gl[j]);
      send(rnd16());
      send(rnd16());
    end

    // R10 overrun
    set_gain(20000, -20000);
    @(negedge clk); smp_stb = 1; smp_data = 16'(12000);
    @(negedge clk); smp_stb = 0;
    repeat (3) @(negedge clk);
    smp_stb = 1; smp_data = 16'(-30000);
    @(negedge clk); smp_stb = 0;
    begin
      longint acc; int q, cnt;
      for (int k = NT - 1; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = 12000;
      acc = 0;
      for (int k = 0; k < NT; k++) acc += longint'(m_hist[k]) * m_coef[k];
      q = sat(acc >>> 15);
      cnt = 0;
      while (!st_vld && cnt < NT + 10) begin @(negedge clk); cnt++; end
      chk("R10 dropped sample ch0", $signed(st_out0), sat((longint'(q) * m_g0) >>> 15));
      chk("R10 dropped sample ch1", $signed(st_out1), sat((longint'(q) * m_g1) >>> 15));
    end
    rd(8'h18, r); chk("R10 overrun set", r, 1);
    wr(8'h18, 32'h0); rd(8'h18, r); chk("R10 write 0 keeps", r, 1);
    wr(8'h18, 32'h1); rd(8'h18, r); chk("R10 write 1 clears", r, 0);
    send(777);

    // R9 disable
    wr(8'h2C, 32'h0);
    @(negedge clk);
    chk("R9 out0 zero", st_out0, 0);
    chk("R9 out1 zero", st_out1, 0);
    seen = 0;
    @(negedge clk); smp_stb = 1; smp_data = 16'(9000);
    @(negedge clk); smp_stb = 0;
    for (int k = 0; k < NT + 5; k++) begin @(negedge clk); if (st_vld) seen = 1; end
    chk("R9 no valid while off", seen, 0);
    rd(8'h18, r); chk("R9 no overrun while off", r, 0);
    hist_clear();
    wr(8'h2C, 32'h1);
    send(-5000);                                  // R9 history was cleared
    send(3000);

    // R6/R7 saturation, both directions
    for (int k = 0; k < NT; k++) m_coef[k] = 32767;
    load_coefs(1'b1);
    wr(8'h2C, 32'h0); hist_clear(); wr(8'h2C, 32'h1);
    set_gain(32767, -32768);
    for (int k = 0; k < NT; k++) send(32767);
    for (int k = 0; k < NT; k++) send(-32768);

    // single-tap pass-through, sample sweep
    for (int k = 0; k < NT; k++) m_coef[k] = (k == 0) ? 32767 : 0;
    load_coefs(1'b1);
    set_gain(32767, 8192);
    for (int v = -32768; v <= 32767; v += 4099) send(v);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule